// File: doc/BRIEF.md
# Power Mode Sequencer

This block tracks which low-power operating mode a microcontroller is in. There are five modes: full-speed active, sleep, subsleep, standby and a low-speed subactive mode. When the CPU executes its sleep instruction, it raises a one-cycle strobe. The sequencer then decodes the next mode from the mode-control bits the CPU has already written. These bits are a standby select, a direct-transition enable, a subsleep select and a low-speed-on flag. While the CPU is halted, an interrupt request from an enabled source wakes the chip, unless the global interrupt mask is set. The low-speed-on flag chooses whether the wake lands in active mode or in subactive mode.

In subactive mode the CPU runs from the low-speed clock divided by 2, 4 or 8. The requested divider code is latched only when a sleep strobe is accepted, so the new rate never takes effect while software is still running. The sequencer drives clock-enable and clock-select indications for the clock tree from its registered state.

The sequencer also owns release from the external reset pin. The pin is synchronised to the clock. Every fall of the pin restarts a programmable settling counter that stands in for oscillator stabilisation. The CPU reset output stays high until the pin is high again and the counter has run out.

Top module: `pwr_mode_seq`

## Requirements
- R1: After the synchronous reset `rst`, the outputs take these values. `mode_oh` is 5'b00001 (active). `sub_div` is 2'b00 (divide by 2). `cpu_rst` is 1. The one-hot bit order is bit0 active, bit1 sleep, bit2 subsleep, bit3 standby, bit4 subactive.
- R2: A sleep strobe accepted in active or subactive mode enters sleep mode, one cycle later, when standby_sel=0, direct_xfer=0 and subsleep_sel=0.
- R3: A sleep strobe accepted in active or subactive mode enters subsleep mode when standby_sel=0, direct_xfer=0 and subsleep_sel=1.
- R4: A sleep strobe accepted in active or subactive mode enters standby mode when standby_sel=1 and direct_xfer=0.
- R5: With direct_xfer=1, a sleep strobe in subactive mode with low_speed_on=0 goes straight to active mode. A sleep strobe in active mode with low_speed_on=1 goes straight to subactive mode.
- R6: In sleep, subsleep or standby mode, a qualified interrupt moves the mode one cycle later. It goes to subactive when low_speed_on=1 and to active when low_speed_on=0. A qualified interrupt is any irq_req bit whose irq_en bit is set, while irq_mask=0. A sleep strobe in the same cycle does not alter this.
- R7: No wake occurs when irq_mask=1, or when no requesting source is enabled.
- R8: The `sub_div` output changes only in the cycle after an accepted sleep strobe. It then takes the value latched from `div_code`. Code 00 gives 00 (divide by 2) and 01 gives 01 (divide by 4). Codes 10 and 11 both give 10 (divide by 8).
- R9: A sleep strobe with any bit combination not listed in R2 to R5 leaves the mode unchanged. A sleep strobe in sleep, subsleep or standby mode is ignored and leaves both the mode and `sub_div` unchanged.
- R10: Once the synchronised reset pin reads low, the mode is forced to active and `cpu_rst` is high. A settling count of `settle_limit` cycles restarts at each fall of the pin. `cpu_rst` falls only after that count has expired and the pin is high, even if the pin returned high earlier.
- R11: `cpu_clk_en` is 1 exactly in active and subactive modes. `subclk_sel` is 1 exactly in subactive mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| res_pin_n | input | 1 | Asynchronous external reset pin, active low |
| settle_limit | input | CNT_W | Oscillator settling count in cycles |
| sleep_req | input | 1 | One-cycle sleep instruction strobe |
| standby_sel | input | 1 | Selects standby on sleep |
| direct_xfer | input | 1 | Direct active/subactive transition enable |
| subsleep_sel | input | 1 | Selects subsleep instead of sleep |
| low_speed_on | input | 1 | Wake or direct transition targets subactive |
| div_code | input | 2 | Requested subactive clock divider code |
| irq_mask | input | 1 | CPU global interrupt mask |
| irq_req | input | NUM_IRQ | Per-source interrupt requests |
| irq_en | input | NUM_IRQ | Per-source interrupt enables |
| mode_oh | output | 5 | One-hot current mode |
| cpu_clk_en | output | 1 | CPU clock running |
| subclk_sel | output | 1 | CPU clock taken from low-speed clock |
| sub_div | output | 2 | Active low-speed clock divider select |
| cpu_rst | output | 1 | Reset to the CPU |

## Verification
Two events can arrive in the same cycle: a sleep strobe and a qualified interrupt. Which one decides the next mode depends only on the current mode. The bench lines up both inputs on the same edge in active, subactive and halted modes, in directed steps and in random traffic. A bench model acts on the strobe only in running modes and on the interrupt only in halted modes, and the bench checks the registered mode and divider against it. The reset pin is also dropped while the sequencer sits in a halted mode. The bench then checks that the forced return to active takes priority and that release waits for the settling count.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  localparam int NMODES = 5;

  typedef enum logic [2:0] {
    M_ACT = 3'd0,
    M_SLP = 3'd1,
    M_SSL = 3'd2,
    M_STB = 3'd3,
    M_SUB = 3'd4
  } pmode_e;

  typedef enum logic [1:0] {
    DIV2 = 2'b00,
    DIV4 = 2'b01,
    DIV8 = 2'b10
  } subdiv_e;

  function automatic subdiv_e map_div(input logic [1:0] code);
    case (code)
      2'b00:   return DIV2;
      2'b01:   return DIV4;
      default: return DIV8;
    endcase
  endfunction

  function automatic pmode_e decode_sleep(input pmode_e cur, input logic sb,
                                          input logic dt, input logic ss,
                                          input logic ls);
    if (!dt && sb)                       return M_STB;
    else if (!dt && !sb)                 return ss ? M_SSL : M_SLP;
    else if (dt && !ls && cur == M_SUB)  return M_ACT;
    else if (dt && ls && cur == M_ACT)   return M_SUB;
    else                                 return cur;
  endfunction

endpackage

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual #(
  parameter int NUM_IRQ = 8
) (
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               irq_mask,
  output logic               wake
);

  logic [NUM_IRQ-1:0] qual;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
    assign qual[i] = irq_req[i] & irq_en[i];
  end

  assign wake = (|qual) & ~irq_mask;

endmodule

// File: rtl/pwr_reset_settle.sv
module pwr_reset_settle #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             res_pin_n,
  input  logic [CNT_W-1:0] settle_limit,
  output logic             pin_low,
  output logic             cpu_rst
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   low_d;
  logic [CNT_W-1:0]       cnt_q;
  logic                   settled;
  logic                   rst_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sync_q[s] <= 1'b0;
        else     sync_q[s] <= ~res_pin_n;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sync_q[s] <= 1'b0;
        else     sync_q[s] <= sync_q[s-1];
      end
    end
  end

  assign pin_low = sync_q[LAST];
  assign settled = (cnt_q >= settle_limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      low_d <= 1'b0;
      cnt_q <= '0;
      rst_q <= 1'b1;
    end else begin
      low_d <= pin_low;
      if (pin_low && !low_d) cnt_q <= '0;
      else if (!settled)     cnt_q <= cnt_q + 1'b1;
      rst_q <= pin_low | ~settled;
    end
  end

  assign cpu_rst = rst_q;

  // R10
  pin_low_holds_reset_chk: assert property (@(posedge clk) disable iff (rst)
    pin_low |=> cpu_rst);

  // R10
  early_release_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_low && !low_d) |=> ##1 cpu_rst);

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_low,
  input  logic              hold,
  input  logic              sleep_req,
  input  logic              standby_sel,
  input  logic              direct_xfer,
  input  logic              subsleep_sel,
  input  logic              low_speed_on,
  input  logic [1:0]        div_code,
  input  logic              wake,
  output logic [NMODES-1:0] mode_oh,
  output logic              cpu_clk_en,
  output logic              subclk_sel,
  output logic [1:0]        sub_div
);

  pmode_e            mode_q, mode_d;
  subdiv_e           div_q;
  logic              accept;
  logic              halted;
  logic [NMODES-1:0] oh_q, oh_d;
  logic              clk_en_q, sub_q;

  assign halted = (mode_q == M_SLP) || (mode_q == M_SSL) || (mode_q == M_STB);

  always_comb begin
    mode_d = mode_q;
    accept = 1'b0;
    if (pin_low) begin
      mode_d = M_ACT;
    end else if (!hold) begin
      unique case (mode_q)
        M_ACT, M_SUB: begin
          if (sleep_req) begin
            accept = 1'b1;
            mode_d = decode_sleep(mode_q, standby_sel, direct_xfer,
                                  subsleep_sel, low_speed_on);
          end
        end
        M_SLP, M_SSL, M_STB: begin
          if (wake) mode_d = low_speed_on ? M_SUB : M_ACT;
        end
        default: mode_d = M_ACT;
      endcase
    end
  end

  always_comb begin
    oh_d         = '0;
    oh_d[mode_d] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= M_ACT;
      oh_q     <= NMODES'(1);
      clk_en_q <= 1'b1;
      sub_q    <= 1'b0;
      div_q    <= DIV2;
    end else begin
      mode_q   <= mode_d;
      oh_q     <= oh_d;
      clk_en_q <= (mode_d == M_ACT) || (mode_d == M_SUB);
      sub_q    <= (mode_d == M_SUB);
      if (accept) div_q <= map_div(div_code);
    end
  end

  assign mode_oh    = oh_q;
  assign cpu_clk_en = clk_en_q;
  assign subclk_sel = sub_q;
  assign sub_div    = div_q;

  // R1
  mode_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(oh_q) == 1);

  // R6
  wake_to_sub_chk: assert property (@(posedge clk) disable iff (rst)
    (halted && wake && low_speed_on && !pin_low && !hold) |=> (mode_q == M_SUB));

  // R7
  no_wake_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (halted && !wake && !pin_low) |=> $stable(mode_q));

  // R8
  div_only_on_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(div_q));

  // R8
  div_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && div_code == 2'b11) |=> (div_q == DIV8));

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
  parameter int NUM_IRQ     = 8,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               res_pin_n,
  input  logic [CNT_W-1:0]   settle_limit,
  input  logic               sleep_req,
  input  logic               standby_sel,
  input  logic               direct_xfer,
  input  logic               subsleep_sel,
  input  logic               low_speed_on,
  input  logic [1:0]         div_code,
  input  logic               irq_mask,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  output logic [4:0]         mode_oh,
  output logic               cpu_clk_en,
  output logic               subclk_sel,
  output logic [1:0]         sub_div,
  output logic               cpu_rst
);

  logic pin_low;
  logic wake;

  pwr_reset_settle #(
    .SYNC_STAGES(SYNC_STAGES),
    .CNT_W      (CNT_W)
  ) u_settle (
    .clk         (clk),
    .rst         (rst),
    .res_pin_n   (res_pin_n),
    .settle_limit(settle_limit),
    .pin_low     (pin_low),
    .cpu_rst     (cpu_rst)
  );

  pwr_wake_qual #(
    .NUM_IRQ(NUM_IRQ)
  ) u_wake (
    .irq_req (irq_req),
    .irq_en  (irq_en),
    .irq_mask(irq_mask),
    .wake    (wake)
  );

  pwr_mode_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .pin_low     (pin_low),
    .hold        (cpu_rst),
    .sleep_req   (sleep_req),
    .standby_sel (standby_sel),
    .direct_xfer (direct_xfer),
    .subsleep_sel(subsleep_sel),
    .low_speed_on(low_speed_on),
    .div_code    (div_code),
    .wake        (wake),
    .mode_oh     (mode_oh),
    .cpu_clk_en  (cpu_clk_en),
    .subclk_sel  (subclk_sel),
    .sub_div     (sub_div)
  );

  // R11
  subclk_implies_run_chk: assert property (@(posedge clk) disable iff (rst)
    subclk_sel |-> cpu_clk_en);

  // R10
  reset_forces_active_chk: assert property (@(posedge clk) disable iff (rst)
    pin_low |=> mode_oh[0]);

endmodule

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;

  localparam int NI = 8;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          res_pin_n;
  logic [CW-1:0] settle_limit;
  logic          sleep_req, standby_sel, direct_xfer, subsleep_sel, low_speed_on;
  logic [1:0]    div_code;
  logic          irq_mask;
  logic [NI-1:0] irq_req, irq_en;
  logic [4:0]    mode_oh;
  logic          cpu_clk_en, subclk_sel, cpu_rst;
  logic [1:0]    sub_div;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int m = 0;   // 0 act,1 sleep,2 subsleep,3 standby,4 subactive
  int d = 0;

  always #2.5 clk = ~clk;

  pwr_mode_seq #(.NUM_IRQ(NI), .CNT_W(CW), .SYNC_STAGES(2)) i_pwr_mode_seq (
    .clk(clk), .rst(rst), .res_pin_n(res_pin_n), .settle_limit(settle_limit),
    .sleep_req(sleep_req), .standby_sel(standby_sel), .direct_xfer(direct_xfer),
    .subsleep_sel(subsleep_sel), .low_speed_on(low_speed_on), .div_code(div_code),
    .irq_mask(irq_mask), .irq_req(irq_req), .irq_en(irq_en), .mode_oh(mode_oh),
    .cpu_clk_en(cpu_clk_en), .subclk_sel(subclk_sel), .sub_div(sub_div),
    .cpu_rst(cpu_rst));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int div_of(input logic [1:0] c);
    return (c == 2'b00) ? 0 : (c == 2'b01) ? 1 : 2;
  endfunction

  task automatic model(input bit slp, input bit sb, input bit dt, input bit ss,
                       input bit ls, input logic [1:0] code, input bit wk,
                       output string tag);
    tag = "R9";
    if (slp && (m == 0 || m == 4)) begin
      d = div_of(code);
      if (!dt && sb)               begin m = 3; tag = "R4"; end
      else if (!dt && !sb)         begin m = ss ? 2 : 1; tag = ss ? "R3" : "R2"; end
      else if (dt && !ls && m == 4) begin m = 0; tag = "R5"; end
      else if (dt && ls && m == 0)  begin m = 4; tag = "R5"; end
    end else if (m >= 1 && m <= 3) begin
      if (wk) begin m = ls ? 4 : 0; tag = "R6"; end
      else tag = "R7";
    end
  endtask

  task automatic check_outs(input string tag);
    chk(mode_oh == 5'(1 << m), tag, "mode_oh", int'(mode_oh), 1 << m);
    chk(int'(sub_div) == d, (tag == "R9") ? "R9" : "R8", "sub_div", int'(sub_div), d);
    chk(cpu_clk_en == (m == 0 || m == 4) && subclk_sel == (m == 4), "R11",
        "clk_en/subclk", {cpu_clk_en, subclk_sel}, {(m == 0 || m == 4), (m == 4)});
  endtask

  task automatic cyc(input bit slp, input bit sb, input bit dt, input bit ss,
                     input bit ls, input logic [1:0] code, input bit msk,
                     input logic [NI-1:0] req, input logic [NI-1:0] en,
                     input string tag);
    string mt;
    sleep_req = slp; standby_sel = sb; direct_xfer = dt; subsleep_sel = ss;
    low_speed_on = ls; div_code = code; irq_mask = msk; irq_req = req; irq_en = en;
    model(slp, sb, dt, ss, ls, code, (|(req & en)) && !msk, mt);
    @(posedge clk);
    @(negedge clk);
    sleep_req = 1'b0;
    irq_req   = '0;
    check_outs((tag == "") ? mt : tag);
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; res_pin_n = 1'b1; settle_limit = CW'(20);
    sleep_req = 0; standby_sel = 0; direct_xfer = 0; subsleep_sel = 0;
    low_speed_on = 0; div_code = 0; irq_mask = 0; irq_req = '0; irq_en = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(mode_oh == 5'b00001, "R1", "mode_oh", int'(mode_oh), 1);
    chk(sub_div == 2'b00, "R1", "sub_div", int'(sub_div), 0);
    chk(cpu_rst == 1'b1, "R1", "cpu_rst", int'(cpu_rst), 1);
    for (int i = 0; i < 60 && cpu_rst; i++) @(negedge clk);
    chk(cpu_rst == 1'b0, "R10", "cpu_rst after settle", int'(cpu_rst), 0);

    // directed sequence
    cyc(1,0,0,0,0,2'b01,0,'0,'0,"R2");          // -> sleep, div4
    cyc(0,0,0,0,1,2'b00,0,8'h01,8'h00,"R7");    // source disabled
    cyc(0,0,0,0,1,2'b00,1,8'h01,8'h01,"R7");    // masked
    cyc(1,0,1,0,1,2'b10,1,'0,'0,"R9");          // strobe ignored while halted
    cyc(0,0,0,0,1,2'b00,0,8'h80,8'h80,"R6");    // wake -> subactive
    cyc(1,0,1,0,0,2'b10,0,'0,'0,"R5");          // subactive -> active, div8
    cyc(1,0,1,0,1,2'b00,0,'0,'0,"R5");          // active -> subactive, div2
    cyc(1,0,1,0,1,2'b11,0,'0,'0,"R9");          // uncovered combo, reserved code
    chk(sub_div == 2'b10, "R8", "reserved code", int'(sub_div), 2);
    cyc(1,0,0,1,0,2'b01,0,'0,'0,"R3");          // -> subsleep
    cyc(1,1,0,0,0,2'b00,0,8'h10,8'h10,"R6");    // wake and strobe together -> active
    cyc(1,1,0,0,0,2'b00,0,'0,'0,"R4");          // -> standby
    cyc(0,0,0,0,0,2'b00,0,'0,'0,"R7");          // idle
    cyc(0,0,0,0,1,2'b00,0,8'h02,8'hFF,"R6");    // -> subactive
    cyc(1,1,0,1,0,2'b10,0,8'h04,8'hFF,"R4");    // strobe+irq in subactive -> standby
    cyc(0,0,0,0,0,2'b00,0,8'h04,8'h04,"R6");    // -> active
    cyc(1,0,0,0,0,2'b01,0,8'hFF,8'hFF,"R2");    // strobe wins in active
    cyc(0,0,0,0,1,2'b00,0,8'h01,8'h01,"R6");

    // constrained random
    for (int k = 0; k < 3000; k++) begin
      logic [NI-1:0] rq;
      rq = (($urandom % 4) == 0) ? NI'($urandom) : '0;
      cyc(($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 3) == 0,
          $urandom % 2, $urandom % 2, 2'($urandom), ($urandom % 4) == 0,
          rq, NI'($urandom), "");
    end

    // R10: short pin pulse while halted, settle count still governs release
    settle_limit = CW'(30);
    cyc(1,0,0,0,0,2'b00,0,'0,'0,"R2");          // -> sleep
    if (m != 1) cyc(1,0,0,0,0,2'b00,0,'0,'0,"R2");
    res_pin_n = 1'b0;
    repeat (3) @(negedge clk);
    res_pin_n = 1'b1;
    @(negedge clk);
    chk(mode_oh == 5'b00001, "R10", "mode during pin reset", int'(mode_oh), 1);
    chk(cpu_rst == 1'b1, "R10", "cpu_rst asserted", int'(cpu_rst), 1);
    repeat (21) @(negedge clk);
    chk(cpu_rst == 1'b1, "R10", "held during settling", int'(cpu_rst), 1);
    repeat (15) @(negedge clk);
    chk(cpu_rst == 1'b0, "R10", "released after settling", int'(cpu_rst), 0);
    m = 0;

    // R10: long pin hold releases soon after pin rises
    res_pin_n = 1'b0;
    repeat (60) @(negedge clk);
    chk(cpu_rst == 1'b1, "R10", "held while pin low", int'(cpu_rst), 1);
    res_pin_n = 1'b1;
    @(negedge clk);
    chk(cpu_rst == 1'b1, "R10", "sync delay", int'(cpu_rst), 1);
    repeat (3) @(negedge clk);
    chk(cpu_rst == 1'b0, "R10", "release after long hold", int'(cpu_rst), 0);
    check_outs("R10");
    cyc(1,0,0,1,0,2'b01,0,'0,'0,"R3");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule